// File: doc/BRIEF.md
# Truncating bfloat16 multiplier

The block multiplies two bfloat16 operands and returns their product as one bfloat16 word, one clock after the operands are presented. It is meant for area-sensitive datapaths that do not need subnormals, NaN or infinity. Operands are assumed to be normal numbers or zero.

The sign of the product is the exclusive OR of the operand signs. The two 8-bit significands, hidden one included, are multiplied into a 16-bit product. That product is normalised by at most one place. The fraction is then cut to 7 bits toward zero. The biased exponents are added and the bias of 127 is taken off once.

Results that would fall below the normal range become a zero that keeps the computed sign. Results above the largest exponent saturate to the largest finite magnitude instead of becoming infinity. As a result, the block needs no special-value logic at all.

Top module: `bf16_trunc_mul`

## Requirements
- R1: The result sign (bit 15) equals the XOR of the operand signs (bit 15 of each) for every result, including zero and saturated results.
- R2: An operand whose exponent field (bits 14:7) is zero counts as zero, whatever its fraction. The result magnitude (bits 14:0) is then 0x0000.
- R3: For normal operands with exponent fields ea and eb and fractions fa and fb, the product P = (128+fa)*(128+fb) is formed. If P >= 32768, the result exponent is ea+eb-126 and the fraction is P[14:8]. Otherwise the result exponent is ea+eb-127 and the fraction is P[13:7].
- R4: Product bits below the kept fraction are discarded and never round the result up. For example, 0x3F3F times 0x3F3F gives 0x3F0E.
- R5: If the R3 exponent is 0 or less, the result magnitude is 0x0000 and the sign still follows R1.
- R6: If the R3 exponent is 255 or more, the result magnitude is 0x7F7F (exponent 0xFE, fraction all ones) and the sign follows R1.
- R7: The output is registered. The result for operands sampled at one rising edge appears after that edge and holds until the next edge. While rst_n is low, the output is 0x0000.
- R8: The output never carries exponent field 0xFF. Whenever its exponent field is zero, its fraction is also zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| a | input | 16 | First bfloat16 operand |
| b | input | 16 | Second bfloat16 operand |
| y | output | 16 | Registered bfloat16 product |

## Verification
The assertions check four things on every cycle against the operands of the previous cycle:
- the output sign;
- the zero result forced by a zero operand;
- saturation and flush for exponent sums far enough out of range that normalisation cannot change the outcome;
- the absence of 0xFF exponents and of nonzero fractions under a zero exponent.

Only the bench's reference comparison can show the exact exponent and fraction of ordinary products. The same holds for the single-place normalisation, for truncation that never rounds up, and for the boundary cases where the normalisation carry decides between flushing, a normal result and saturation.

// File: rtl/bf16_trunc_mul.sv
module bf16_trunc_mul #(
  parameter int EW = 8,
  parameter int FW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EW+FW:0]    a,
  input  logic [EW+FW:0]    b,
  output logic [EW+FW:0]    y
);
  localparam int W    = 1 + EW + FW;
  localparam int MW   = FW + 1;
  localparam int PW   = 2 * MW;
  localparam int XW   = EW + 2;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int EMAX = (1 << EW) - 2;

  logic [EW-1:0] ea, eb;
  logic [MW-1:0] ma, mb;
  logic [PW-1:0] prod;
  logic          norm, zero_in, sgn, under, over;
  logic [FW-1:0] frac;
  logic [XW-1:0] xs;
  logic [W-1:0]  res;

  assign ea      = a[W-2:FW];
  assign eb      = b[W-2:FW];
  assign zero_in = (ea == '0) || (eb == '0);
  assign sgn     = a[W-1] ^ b[W-1];
  assign ma      = {1'b1, a[FW-1:0]};
  assign mb      = {1'b1, b[FW-1:0]};
  assign prod    = ma * mb;
  assign norm    = prod[PW-1];
  assign frac    = norm ? prod[PW-2 -: FW] : prod[PW-3 -: FW];
  assign xs      = XW'(ea) + XW'(eb) + XW'(norm) - XW'(BIAS);
  assign under   = xs[XW-1] || (xs == '0);
  assign over    = !xs[XW-1] && (xs > XW'(EMAX));

  always_comb begin
    if (zero_in || under)
      res = {sgn, {(W-1){1'b0}}};
    else if (over)
      res = {sgn, EW'(EMAX), {FW{1'b1}}};
    else
      res = {sgn, xs[EW-1:0], frac};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) y <= '0;
    else        y <= res;
  end

  logic live;
  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  assert_sign_xor_R1: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> y[W-1] == ($past(a[W-1]) ^ $past(b[W-1])));

  assert_zero_operand_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ($past(a[W-2:FW]) == '0 || $past(b[W-2:FW]) == '0)) |-> y[W-2:0] == '0);

  assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(a[W-2:FW]) != '0 && $past(b[W-2:FW]) != '0 &&
     (int'($past(a[W-2:FW])) + int'($past(b[W-2:FW])) <= BIAS - 1)) |-> y[W-2:0] == '0);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && (int'($past(a[W-2:FW])) + int'($past(b[W-2:FW])) >= EMAX + 1 + BIAS))
      |-> y[W-2:0] == {EW'(EMAX), {FW{1'b1}}});

  assert_no_special_R8: assert property (@(posedge clk) disable iff (!rst_n)
    y[W-2:FW] != {EW{1'b1}});

  assert_clean_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (y[W-2:FW] == '0) |-> (y[FW-1:0] == '0));

  assert_reset_clear_R7: assert property (@(posedge clk)
    !rst_n |=> y == '0);
endmodule

// File: tb/bf16_trunc_mul_test.sv
module bf16_trunc_mul_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [15:0] y;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bf16_trunc_mul uut (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .y(y));

  function automatic logic [15:0] ref_mul(input logic [15:0] x, input logic [15:0] z);
    int ex, ez, p, e, f, s;
    s  = x[15] ^ z[15];
    ex = x[14:7];
    ez = z[14:7];
    if (ex == 0 || ez == 0) return {s[0], 15'h0000};
    p = (128 + x[6:0]) * (128 + z[6:0]);
    if (p >= 32768) begin e = ex + ez - 126; f = (p / 256) % 128; end
    else            begin e = ex + ez - 127; f = (p / 128) % 128; end
    if (e <= 0)   return {s[0], 15'h0000};
    if (e >= 255) return {s[0], 15'h7F7F};
    return {s[0], e[7:0], f[6:0]};
  endfunction

  function automatic string tag_of(input logic [15:0] x, input logic [15:0] z);
    int e;
    if (x[14:7] == 0 || z[14:7] == 0) return "R2";
    e = int'(x[14:7]) + int'(z[14:7]) - 127;
    if (e <= 0) return "R5";
    if (e >= 255) return "R6";
    return "R3";
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] z, input string req);
    logic [15:0] e;
    @(negedge clk);
    a = x; b = z;
    e = ref_mul(x, z);
    @(negedge clk);
    check(req, y, e);
    check("R1", {15'h0, y[15]}, {15'h0, x[15] ^ z[15]});
    check("R8", {15'h0, (y[14:7] == 8'hFF) || (y[14:7] == 0 && y[6:0] != 0)}, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a = 16'h4040; b = 16'h4040;
    repeat (3) @(negedge clk);
    check("R7", y, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", y, 16'h4110);

    apply(16'h3F80, 16'h4000, "R3");
    apply(16'h4040, 16'h4040, "R3");
    apply(16'hC040, 16'h3FC0, "R3");
    apply(16'h3FFF, 16'h3FFF, "R3");
    apply(16'h3F80, 16'h7F7F, "R3");
    apply(16'h3F3F, 16'h3F3F, "R4");
    check("R4", y, 16'h3F0E);
    apply(16'h8000, 16'h4000, "R2");
    apply(16'h0012, 16'hC123, "R2");
    apply(16'h0080, 16'h0080, "R5");
    apply(16'h8080, 16'h0080, "R5");
    apply(16'h0080, 16'h3F00, "R5");
    apply(16'h0080, 16'h3F80, "R3");
    apply(16'h7F7F, 16'h7F7F, "R6");
    apply(16'hFF7F, 16'h7F7F, "R6");
    apply(16'h7F00, 16'h4000, "R6");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] x, z;
      x = 16'($urandom);
      z = 16'($urandom);
      if (x[14:7] == 8'hFF) x[14:7] = 8'hFE;
      if (z[14:7] == 8'hFF) z[14:7] = 8'hFE;
      if (i % 5 == 0) x[14:7] = 8'(7'($urandom) + 8'd64);
      if (i % 5 == 1) z[14:7] = 8'(7'($urandom) + 8'd64);
      if (i % 97 == 0) x[14:7] = 8'h00;
      apply(x, z, tag_of(x, z));
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7", y, 16'h0000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule